// File: doc/BRIEF.md
# Memory Power-State Sequencer

This block sits between user logic and a single-port RAM macro that exposes three power-control lines: a power line (high means supplied), a sleep line and a standby line. User logic asks for one of four modes (run, standby, sleep, off) through a four-phase request/acknowledge handshake. The sequencer drives the three lines to match and models the wake-up time of two internal power domains inside the macro: a quick standby domain and a slow main domain. Each domain has its own down-counter, and each counter restarts on a different edge of the control lines.

The RAM counts as usable (`mem_ready`) only when the lines select run and both domain counters have reached zero. Until then, user read and write strobes are blocked from the macro and answered with `usr_busy`. They are dropped, not held for later. Read data seen by the user is forced to zero while the macro is not usable. The exception is standby, where the last value is held. A sticky `contents_lost` flag records that a power-off has wiped the array. Sleep and standby keep the contents.

The state machine has three states. ST_IDLE waits for `mode_req` and latches `mode_sel`, moving to ST_APPLY. ST_APPLY writes the three lines and moves to ST_ACK. ST_ACK asserts `mode_ack` and stays there until `mode_req` falls, then returns to ST_IDLE. Delays are given in time units together with the clock period in the same units, and are rounded up to whole cycles. With the defaults this gives 418 cycles for the main domain and 17 cycles for the standby domain.

Top module: `mem_pwr_seq`

## Requirements
- R1: After synchronous reset the lines show off (`ram_pwr`=0, `ram_sleep`=0, `ram_stby`=0), `mem_ready`=0, `mode_ack`=0, `contents_lost`=1, and both counters hold their full delay.
- R2: `mode_sel` encoding is 0=run, 1=standby, 2=sleep, 3=off. The lines {`ram_pwr`,`ram_sleep`,`ram_stby`} become 100 for run, 101 for standby, 110 for sleep and 000 for off.
- R3: With `mode_req` first seen high at clock edge k, the lines change at edge k+1, and `mode_ack` is high from that edge on. `mode_ack` stays high with the lines unchanged while `mode_req` stays high, and falls at the first edge that sees `mode_req` low.
- R4: The main counter reloads to its full cycle count when `ram_pwr` rises or `ram_sleep` falls. Waking from off or sleep, `mem_ready` rises exactly MAIN cycles after the cycle in which `mode_ack` first shows high.
- R5: The standby counter reloads when `ram_stby` falls. Returning from standby to run, `mem_ready` rises exactly STBY cycles after `mode_ack` first shows high.
- R6: `mem_ready` is high only when the lines read 100 and both counters are zero.
- R7: While `mem_ready` is low, a user read or write strobe gives `usr_busy`=1 and `ram_en`=`ram_we`=0. Such a strobe is not replayed once ready returns. While ready, a write gives `ram_en`=`ram_we`=1 and `usr_busy`=0.
- R8: While ready, a read strobe in cycle c puts `ram_rdata` from cycle c+1 on `usr_rdata` from cycle c+2. Outside standby, `usr_rdata` becomes zero one cycle after any cycle in which `mem_ready` is low.
- R9: While `ram_stby` is high, `usr_rdata` keeps its value.
- R10: `contents_lost` sets at the edge where `ram_pwr` falls, and clears on `lost_ack`. Setting wins over clearing. Entering sleep or standby does not set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_req | input | 1 | Mode change request (four-phase) |
| mode_sel | input | 2 | Requested mode: 0 run, 1 standby, 2 sleep, 3 off |
| mode_ack | output | 1 | Lines updated for the requested mode |
| usr_rd | input | 1 | User read strobe |
| usr_wr | input | 1 | User write strobe |
| usr_busy | output | 1 | Strobe refused because the RAM is not ready |
| usr_rdata | output | DW | Read data returned to the user |
| ram_en | output | 1 | Gated access enable to the macro |
| ram_we | output | 1 | Gated write enable to the macro |
| ram_rdata | input | DW | Read data from the macro |
| ram_pwr | output | 1 | Power line to the macro, high = supplied |
| ram_sleep | output | 1 | Sleep line to the macro |
| ram_stby | output | 1 | Standby line to the macro |
| mem_ready | output | 1 | Both domains awake and mode is run |
| contents_lost | output | 1 | Sticky: array contents invalid |
| lost_ack | input | 1 | Clears `contents_lost` |

## Verification
The bench measures wake-up latency cycle by cycle for each kind of wake: off to run and sleep to run use the main counter, standby to run uses only the standby counter. A design that reloaded the wrong counter on a given edge, or reloaded on the wrong polarity, would report ready hundreds of cycles early or late. Read data is followed through standby, where a design that cleared it would lose the held word, and through the post-standby wake, where a design that kept it would leak stale data. A strobe made while waking must not reach the macro later. A queued design would raise `ram_en` once ready returns. The bench also checks that sleep and standby leave `contents_lost` clear, which a flag wired to any mode change would fail.

// File: rtl/mps_pkg.sv
package mps_pkg;

    typedef enum logic [1:0] {
        MODE_RUN   = 2'd0,
        MODE_STBY  = 2'd1,
        MODE_SLEEP = 2'd2,
        MODE_OFF   = 2'd3
    } pmode_e;

    typedef struct packed {
        logic pwr;
        logic slp;
        logic stb;
    } plines_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_APPLY = 2'd1,
        ST_ACK   = 2'd2
    } fsm_e;

    function automatic plines_t lines_for(input pmode_e m);
        plines_t l;
        unique case (m)
            MODE_RUN:   l = '{pwr: 1'b1, slp: 1'b0, stb: 1'b0};
            MODE_STBY:  l = '{pwr: 1'b1, slp: 1'b0, stb: 1'b1};
            MODE_SLEEP: l = '{pwr: 1'b1, slp: 1'b1, stb: 1'b0};
            default:    l = '{pwr: 1'b0, slp: 1'b0, stb: 1'b0};
        endcase
        return l;
    endfunction

endpackage

// File: rtl/mps_dly_timer.sv
module mps_dly_timer #(
    parameter int CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic reload,
    output logic done
);
    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] FULL = CW'(CYCLES);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || reload) begin
            cnt <= FULL;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/mps_mode_fsm.sv
module mps_mode_fsm
    import mps_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       mode_req,
    input  logic [1:0] mode_sel,
    output logic       mode_ack,
    output plines_t    lines,
    output logic       main_reload,
    output logic       stby_reload,
    output logic       pwr_drop
);
    fsm_e    st, st_nxt;
    pmode_e  tgt;
    plines_t tgt_lines;

    assign tgt_lines = lines_for(tgt);

    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_IDLE:  if (mode_req) st_nxt = ST_APPLY;
            ST_APPLY: st_nxt = ST_ACK;
            ST_ACK:   if (!mode_req) st_nxt = ST_IDLE;
            default:  st_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            tgt   <= MODE_OFF;
            lines <= lines_for(MODE_OFF);
        end else begin
            st <= st_nxt;
            if (st == ST_IDLE && mode_req) tgt <= pmode_e'(mode_sel);
            if (st == ST_APPLY) lines <= tgt_lines;
        end
    end

    always_comb begin
        mode_ack    = (st == ST_ACK);
        main_reload = (st == ST_APPLY) &&
                      ((tgt_lines.pwr && !lines.pwr) || (!tgt_lines.slp && lines.slp));
        stby_reload = (st == ST_APPLY) && !tgt_lines.stb && lines.stb;
        pwr_drop    = (st == ST_APPLY) && !tgt_lines.pwr && lines.pwr;
    end
endmodule

// File: rtl/mps_access_gate.sv
module mps_access_gate #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ready,
    input  logic          stb_line,
    input  logic          usr_rd,
    input  logic          usr_wr,
    input  logic [DW-1:0] ram_rdata,
    output logic          ram_en,
    output logic          ram_we,
    output logic          usr_busy,
    output logic [DW-1:0] usr_rdata
);
    logic rd_q;

    assign ram_en   = ready && (usr_rd || usr_wr);
    assign ram_we   = ready && usr_wr;
    assign usr_busy = !ready && (usr_rd || usr_wr);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q      <= 1'b0;
            usr_rdata <= '0;
        end else begin
            rd_q <= ready && usr_rd && !usr_wr;
            if (stb_line) begin
                usr_rdata <= usr_rdata;
            end else if (!ready) begin
                usr_rdata <= '0;
            end else if (rd_q) begin
                usr_rdata <= ram_rdata;
            end
        end
    end
endmodule

// File: rtl/mem_pwr_seq.sv
module mem_pwr_seq
    import mps_pkg::*;
#(
    parameter int DW        = 16,
    parameter int TICK      = 100,
    parameter int MAIN_DLY  = 41800,
    parameter int STBY_DLY  = 1700
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mode_req,
    input  logic [1:0]    mode_sel,
    output logic          mode_ack,
    input  logic          usr_rd,
    input  logic          usr_wr,
    output logic          usr_busy,
    output logic [DW-1:0] usr_rdata,
    output logic          ram_en,
    output logic          ram_we,
    input  logic [DW-1:0] ram_rdata,
    output logic          ram_pwr,
    output logic          ram_sleep,
    output logic          ram_stby,
    output logic          mem_ready,
    output logic          contents_lost,
    input  logic          lost_ack
);
    localparam int MAIN_CYC = (MAIN_DLY + TICK - 1) / TICK;
    localparam int STBY_CYC = (STBY_DLY + TICK - 1) / TICK;

    plines_t lines;
    logic    main_reload, stby_reload, pwr_drop;
    logic    main_done, stby_done;

    mps_mode_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .mode_req    (mode_req),
        .mode_sel    (mode_sel),
        .mode_ack    (mode_ack),
        .lines       (lines),
        .main_reload (main_reload),
        .stby_reload (stby_reload),
        .pwr_drop    (pwr_drop)
    );

    mps_dly_timer #(.CYCLES(MAIN_CYC)) u_main_tmr (
        .clk    (clk),
        .rst    (rst),
        .reload (main_reload),
        .done   (main_done)
    );

    mps_dly_timer #(.CYCLES(STBY_CYC)) u_stby_tmr (
        .clk    (clk),
        .rst    (rst),
        .reload (stby_reload),
        .done   (stby_done)
    );

    assign ram_pwr   = lines.pwr;
    assign ram_sleep = lines.slp;
    assign ram_stby  = lines.stb;
    assign mem_ready = lines.pwr && !lines.slp && !lines.stb && main_done && stby_done;

    mps_access_gate #(.DW(DW)) u_gate (
        .clk       (clk),
        .rst       (rst),
        .ready     (mem_ready),
        .stb_line  (lines.stb),
        .usr_rd    (usr_rd),
        .usr_wr    (usr_wr),
        .ram_rdata (ram_rdata),
        .ram_en    (ram_en),
        .ram_we    (ram_we),
        .usr_busy  (usr_busy),
        .usr_rdata (usr_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            contents_lost <= 1'b1;
        end else if (pwr_drop) begin
            contents_lost <= 1'b1;
        end else if (lost_ack) begin
            contents_lost <= 1'b0;
        end
    end
endmodule

// File: rtl/mem_pwr_seq_chk.sv
module mem_pwr_seq_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          mode_req,
    input logic          mode_ack,
    input logic          usr_rd,
    input logic          usr_wr,
    input logic          usr_busy,
    input logic [DW-1:0] usr_rdata,
    input logic          ram_en,
    input logic          ram_we,
    input logic          ram_pwr,
    input logic          ram_sleep,
    input logic          ram_stby,
    input logic          mem_ready,
    input logic          contents_lost
);
    p_ack_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (mode_ack && mode_req) |=> (mode_ack && $stable({ram_pwr, ram_sleep, ram_stby})));

    p_wake_blocked_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(ram_pwr) |-> !mem_ready);

    p_ready_lines_r6: assert property (@(posedge clk) disable iff (rst)
        mem_ready |-> (ram_pwr && !ram_sleep && !ram_stby));

    p_gate_r7: assert property (@(posedge clk) disable iff (rst)
        !mem_ready |-> (!ram_en && !ram_we));

    p_busy_r7: assert property (@(posedge clk) disable iff (rst)
        ((usr_rd || usr_wr) && !mem_ready) |-> usr_busy);

    p_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (!mem_ready && !ram_stby) |=> (usr_rdata == '0));

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        ram_stby |=> $stable(usr_rdata));

    p_lost_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(ram_pwr) |-> contents_lost);
endmodule

bind mem_pwr_seq mem_pwr_seq_chk #(.DW(DW)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .mode_req      (mode_req),
    .mode_ack      (mode_ack),
    .usr_rd        (usr_rd),
    .usr_wr        (usr_wr),
    .usr_busy      (usr_busy),
    .usr_rdata     (usr_rdata),
    .ram_en        (ram_en),
    .ram_we        (ram_we),
    .ram_pwr       (ram_pwr),
    .ram_sleep     (ram_sleep),
    .ram_stby      (ram_stby),
    .mem_ready     (mem_ready),
    .contents_lost (contents_lost)
);

// File: tb/sim_mem_pwr_seq.sv
module sim_mem_pwr_seq;
    localparam int CLK_P    = 10;
    localparam int DW       = 16;
    localparam int MAIN_CYC = 418;
    localparam int STBY_CYC = 17;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          mode_req = 1'b0;
    logic [1:0]    mode_sel = 2'd0;
    logic          mode_ack;
    logic          usr_rd = 1'b0;
    logic          usr_wr = 1'b0;
    logic          usr_busy;
    logic [DW-1:0] usr_rdata;
    logic          ram_en, ram_we;
    logic [DW-1:0] ram_rdata = '0;
    logic          ram_pwr, ram_sleep, ram_stby;
    logic          mem_ready, contents_lost;
    logic          lost_ack = 1'b0;

    int vecs = 0;
    int errs = 0;
    int cyc  = 0;
    int ack_cyc = 0;
    bit finished = 1'b0;

    typedef struct {
        int            due;
        logic [DW-1:0] exp;
        string         req;
    } rd_item_t;
    rd_item_t sb[$];

    always #(CLK_P/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    mem_pwr_seq u0 (
        .clk(clk), .rst(rst), .mode_req(mode_req), .mode_sel(mode_sel),
        .mode_ack(mode_ack), .usr_rd(usr_rd), .usr_wr(usr_wr),
        .usr_busy(usr_busy), .usr_rdata(usr_rdata), .ram_en(ram_en),
        .ram_we(ram_we), .ram_rdata(ram_rdata), .ram_pwr(ram_pwr),
        .ram_sleep(ram_sleep), .ram_stby(ram_stby), .mem_ready(mem_ready),
        .contents_lost(contents_lost), .lost_ack(lost_ack)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // monitor: compares queued read results when they fall due
    always @(negedge clk) begin
        if (sb.size() > 0 && sb[0].due == cyc) begin
            chk(sb[0].req, 32'(usr_rdata), 32'(sb[0].exp));
            void'(sb.pop_front());
        end
    end

    task automatic do_read(input logic [DW-1:0] val, input string req);
        rd_item_t it;
        @(negedge clk);
        ram_rdata = val;
        usr_rd = 1'b1;
        it.due = cyc + 2;
        it.exp = val;
        it.req = req;
        sb.push_back(it);
        @(negedge clk);
        usr_rd = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic set_mode(input logic [1:0] m, input logic [2:0] exp_lines);
        int n;
        @(negedge clk);
        mode_sel = m;
        mode_req = 1'b1;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!mode_ack && n < 10);
        chk("R3 ack latency", 32'(n), 32'd2);
        chk("R2 lines", 32'({ram_pwr, ram_sleep, ram_stby}), 32'(exp_lines));
        ack_cyc = cyc;
        repeat (2) begin
            @(negedge clk);
            chk("R3 ack held", 32'(mode_ack), 32'd1);
        end
        mode_req = 1'b0;
        @(negedge clk);
        chk("R3 ack drop", 32'(mode_ack), 32'd0);
    endtask

    task automatic wait_ready(input int exp_lat, input string req);
        while (!mem_ready && (cyc - ack_cyc) < 2000) @(negedge clk);
        chk(req, 32'(cyc - ack_cyc), 32'(exp_lat));
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!finished) begin
            errs++;
            $display("FAIL watchdog: actual hung, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 lines", 32'({ram_pwr, ram_sleep, ram_stby}), 32'b000);
        chk("R1 ready", 32'(mem_ready), 32'd0);
        chk("R1 lost", 32'(contents_lost), 32'd1);
        chk("R1 ack", 32'(mode_ack), 32'd0);

        // off -> run: main counter, R4
        set_mode(2'd0, 3'b100);
        wait_ready(MAIN_CYC, "R4 off->run latency");
        chk("R6 ready in run", 32'(mem_ready), 32'd1);

        // R10 clear by ack
        @(negedge clk); lost_ack = 1'b1;
        @(negedge clk); lost_ack = 1'b0;
        chk("R10 cleared", 32'(contents_lost), 32'd0);

        // R7 write passes when ready
        @(negedge clk); usr_wr = 1'b1;
        #1;
        chk("R7 wr en", 32'({ram_en, ram_we, usr_busy}), 32'b110);
        @(negedge clk); usr_wr = 1'b0;

        // R8 read path
        do_read(16'hA5C3, "R8 read A");

        // standby: R2, R6, R9, R7, R10
        set_mode(2'd1, 3'b101);
        chk("R6 not ready in standby", 32'(mem_ready), 32'd0);
        repeat (5) @(negedge clk);
        chk("R9 hold in standby", 32'(usr_rdata), 32'hA5C3);
        usr_rd = 1'b1;
        #1;
        chk("R7 blocked strobe", 32'({ram_en, ram_we, usr_busy}), 32'b001);
        @(negedge clk); usr_rd = 1'b0;
        chk("R10 standby keeps", 32'(contents_lost), 32'd0);

        // standby -> run: standby counter only, R5
        set_mode(2'd0, 3'b100);
        wait_ready(STBY_CYC, "R5 stby->run latency");
        chk("R7 not replayed", 32'(ram_en), 32'd0);
        chk("R8 zero after wake", 32'(usr_rdata), 32'd0);
        do_read(16'h3C5A, "R8 read B");

        // sleep: R2, R8, R10
        set_mode(2'd2, 3'b110);
        repeat (2) @(negedge clk);
        chk("R8 zero in sleep", 32'(usr_rdata), 32'd0);
        chk("R10 sleep keeps", 32'(contents_lost), 32'd0);

        // sleep -> run: main counter, R4
        set_mode(2'd0, 3'b100);
        wait_ready(MAIN_CYC, "R4 sleep->run latency");
        do_read(16'h0F0F, "R8 read C");

        // off: R2, R10, R6
        set_mode(2'd3, 3'b000);
        chk("R10 lost on off", 32'(contents_lost), 32'd1);
        chk("R6 not ready off", 32'(mem_ready), 32'd0);
        usr_wr = 1'b1;
        #1;
        chk("R7 write blocked off", 32'({ram_en, ram_we, usr_busy}), 32'b001);
        @(negedge clk); usr_wr = 1'b0;
        chk("R8 queue drained", 32'(sb.size()), 32'd0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule